// File: doc/BRIEF.md
# SD Command Issue Engine

This block sends a single SD/MMC command on a one-bit, open-drive style command line and collects the card's reply if one is expected. The host puts the 6-bit command index, the 32-bit argument, three setup flags (reply expected, long reply, skip CRC check) and a 16-bit timeout count on the inputs, then pulses `start`. The engine derives the card clock from the system clock and serialises a 48-bit frame with its CRC7. It then watches the line for a reply start bit and shifts in a 48-bit or 136-bit reply. At the end it publishes the reply words and a set of sticky error flags.

The card clock `sd_clk` runs at the system clock divided by `CLK_DIV`. The engine changes `cmd_out` and samples `cmd_in` on the falling edge of `sd_clk`. A card model therefore samples and drives on the rising edge.

Top module: `sd_cmd_issuer`

## Requirements
- R1: After `start`, the engine emits exactly 48 bits on `cmd_out`, MSB first, with `cmd_oe` high. The order is: 0, 1, the 6-bit index, the 32-bit argument, then CRC7 (generator x^7+x^3+1, register cleared, over the first 40 bits), then 1. For index 0 with argument 0 the frame is 0x400000000095.
- R2: When not sending, `cmd_oe` is low and `cmd_out` is high.
- R3: `cmd_busy` is high from `start` until the last frame bit has been sent. `busy` is high from `start` until the command finishes. With no reply expected, `busy` falls right after the frame.
- R4: A short reply is 48 bits. `resp0` receives reply bits 39:8, and `resp1` to `resp3` keep their previous values.
- R5: A long reply is 136 bits, used only when a reply is expected. `resp0` to `resp3` receive reply bits 31:0, 63:32, 95:64 and 127:96.
- R6: Unless skip-CRC is set, `err_crc` is set when the received CRC field (bits 7:1) differs from the CRC7 of the covered bits. Those bits are 47:8 for a short reply and 127:8 for a long reply. With skip-CRC set, `err_crc` stays low.
- R7: `err_end` is set when the last reply bit is 0.
- R8: If no 0 is seen on `cmd_in` for `timeout_units`×`TO_UNIT` card clocks after the frame, `err_timeout` is set and the command ends. `timeout_units` must be nonzero.
- R9: The error flags clear when a command starts and then hold their value until the next start.
- R10: A `start` pulse while `busy` is high is ignored.
- R11: After reset `busy`, `cmd_busy`, `cmd_oe` and all error flags are 0, `cmd_out` is 1 and all reply words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that launches a command |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| want_resp | input | 1 | A reply is expected |
| long_resp | input | 1 | Reply is 136 bits (with `want_resp`) |
| skip_crc | input | 1 | Do not check the reply CRC |
| timeout_units | input | TO_W | Reply timeout in units of `TO_UNIT` card clocks |
| sd_clk | output | 1 | Card clock |
| cmd_out | output | 1 | Command line output value |
| cmd_oe | output | 1 | Command line output enable |
| cmd_in | input | 1 | Command line input |
| cmd_busy | output | 1 | Frame being sent |
| busy | output | 1 | Command in progress |
| err_crc | output | 1 | Reply CRC mismatch |
| err_end | output | 1 | Reply end bit was 0 |
| err_timeout | output | 1 | No reply start bit in time |
| resp0 | output | 32 | Reply word 0 |
| resp1 | output | 32 | Reply word 1 |
| resp2 | output | 32 | Reply word 2 |
| resp3 | output | 32 | Reply word 3 |

## Verification
The bench targets the fixed frame for index 0, which catches a wrong CRC polynomial or a wrong bit order at once. It checks the exact card-clock count at which a missing reply times out, for one and two units, so an off-by-one in the limit shows up as a shifted count. Corrupted CRC and end bits are tested with and without skip-CRC, and a short reply must leave the upper words untouched. A design that decoded the long-reply CRC over the wrong range, or that let a mid-frame `start` reload the frame, would fail the random or the directed checks.

// File: rtl/sd_cmd_issuer.sv
module sd_cmd_issuer #(
  parameter int CLK_DIV = 4,
  parameter int TO_UNIT = 4096,
  parameter int TO_W    = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [5:0]      cmd_index,
  input  logic [31:0]     cmd_arg,
  input  logic            want_resp,
  input  logic            long_resp,
  input  logic            skip_crc,
  input  logic [TO_W-1:0] timeout_units,
  output logic            sd_clk,
  output logic            cmd_out,
  output logic            cmd_oe,
  input  logic            cmd_in,
  output logic            cmd_busy,
  output logic            busy,
  output logic            err_crc,
  output logic            err_end,
  output logic            err_timeout,
  output logic [31:0]     resp0,
  output logic [31:0]     resp1,
  output logic [31:0]     resp2,
  output logic [31:0]     resp3
);
  localparam int DW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int WW = TO_W + $clog2(TO_UNIT) + 1;

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_SEND, S_WAIT, S_RECV} st_t;

  function automatic logic [6:0] crc7(input logic [119:0] d, input int n);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = 119; i >= 0; i--) begin
      if (i >= 120 - n) begin
        fb = d[i] ^ c[6];
        c  = {c[5:0], 1'b0} ^ {3'b000, fb, 2'b00, fb};
      end
    end
    return c;
  endfunction

  st_t             st;
  logic [DW-1:0]   dcnt;
  logic            tick;
  logic [47:0]     tx;
  logic [135:0]    rx;
  logic [135:0]    rx_next;
  logic [7:0]      bcnt;
  logic [WW-1:0]   wcnt, limit_q;
  logic            resp_q, long_q, skip_q, crc_ok;
  logic [39:0]     head;

  assign tick     = (dcnt == DW'(CLK_DIV - 1));
  assign sd_clk   = (dcnt >= DW'(CLK_DIV / 2));
  assign cmd_oe   = (st == S_SEND);
  assign cmd_out  = (st == S_SEND) ? tx[47] : 1'b1;
  assign cmd_busy = (st == S_ARM) || (st == S_SEND);
  assign busy     = (st != S_IDLE);
  assign head     = {2'b01, cmd_index, cmd_arg};
  assign rx_next  = {rx[134:0], cmd_in};
  assign crc_ok   = long_q ? (crc7(rx_next[127:8], 120) == rx_next[7:1])
                           : (crc7({rx_next[47:8], 80'd0}, 40) == rx_next[7:1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dcnt <= '0;
    else        dcnt <= tick ? '0 : dcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tx <= '0; rx <= '0; bcnt <= '0; wcnt <= '0; limit_q <= '0;
      resp_q <= 1'b0; long_q <= 1'b0; skip_q <= 1'b0;
      err_crc <= 1'b0; err_end <= 1'b0; err_timeout <= 1'b0;
      resp0 <= '0; resp1 <= '0; resp2 <= '0; resp3 <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          tx          <= {head, crc7({head, 80'd0}, 40), 1'b1};
          resp_q      <= want_resp;
          long_q      <= want_resp & long_resp;
          skip_q      <= skip_crc;
          limit_q     <= WW'(timeout_units) * WW'(TO_UNIT);
          err_crc     <= 1'b0;
          err_end     <= 1'b0;
          err_timeout <= 1'b0;
          st          <= S_ARM;
        end
        S_ARM: if (tick) begin
          bcnt <= 8'd47;
          st   <= S_SEND;
        end
        S_SEND: if (tick) begin
          if (bcnt == 8'd0) begin
            wcnt <= '0;
            st   <= resp_q ? S_WAIT : S_IDLE;
          end else begin
            tx   <= {tx[46:0], 1'b0};
            bcnt <= bcnt - 1'b1;
          end
        end
        S_WAIT: if (tick) begin
          if (!cmd_in) begin
            rx   <= '0;
            bcnt <= long_q ? 8'd134 : 8'd46;
            st   <= S_RECV;
          end else if (wcnt == limit_q - WW'(1)) begin
            err_timeout <= 1'b1;
            st          <= S_IDLE;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        S_RECV: if (tick) begin
          rx <= rx_next;
          if (bcnt == 8'd0) begin
            err_end <= ~cmd_in;
            err_crc <= ~skip_q & ~crc_ok;
            if (long_q) begin
              resp0 <= rx_next[31:0];
              resp1 <= rx_next[63:32];
              resp2 <= rx_next[95:64];
              resp3 <= rx_next[127:96];
            end else begin
              resp0 <= rx_next[39:8];
            end
            st <= S_IDLE;
          end else begin
            bcnt <= bcnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_busy_needs_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_start_clears_errors_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !err_crc && !err_end && !err_timeout));

  assert_errors_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && !$past(start)) |-> $stable({err_crc, err_end, err_timeout}));

  assert_words_move_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({resp1, resp2, resp3}) |-> $fell(busy));

  assert_oe_within_command_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> (cmd_busy && busy));

  assert_timeout_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |-> (!err_crc && !err_end));
endmodule

// File: tb/tb_sd_cmd_issuer.sv
module tb_sd_cmd_issuer;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [5:0] cmd_index = '0;
  logic [31:0] cmd_arg = '0;
  logic want_resp = 1'b0, long_resp = 1'b0, skip_crc = 1'b0;
  logic [15:0] timeout_units = 16'd1;
  logic sd_clk, cmd_out, cmd_oe, cmd_in = 1'b1;
  logic cmd_busy, busy, err_crc, err_end, err_timeout;
  logic [31:0] resp0, resp1, resp2, resp3;
  int total = 0, bad = 0;
  logic [31:0] er[4];

  always #4 clk = ~clk;

  sd_cmd_issuer dut (.clk, .rst_n, .start, .cmd_index, .cmd_arg, .want_resp, .long_resp,
    .skip_crc, .timeout_units, .sd_clk, .cmd_out, .cmd_oe, .cmd_in, .cmd_busy, .busy,
    .err_crc, .err_end, .err_timeout, .resp0, .resp1, .resp2, .resp3);

  function automatic logic [6:0] bcrc(input logic [135:0] d, input int hi, input int lo);
    logic [6:0] c = '0;
    for (int i = hi; i >= lo; i--) begin
      logic fb = d[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [135:0] act, input logic [135:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input bit wr, input bit lr,
                         input bit sk, input logic [15:0] tmo, input bit respond,
                         input logic [135:0] rf, input int dly, input bit poke,
                         output logic [47:0] cap, output int n);
    int got = 0;
    int nb;
    @(negedge clk);
    cmd_index = idx; cmd_arg = arg; want_resp = wr; long_resp = lr; skip_crc = sk;
    timeout_units = tmo; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && cmd_busy === 1'b1, "R3 busy after start", {busy, cmd_busy}, 2'b11);
    cap = '0;
    while (got < 48) begin
      @(posedge sd_clk); #1;
      if (cmd_oe) begin
        cap = {cap[46:0], cmd_out};
        got++;
        if (poke && got == 10) begin
          @(negedge clk); cmd_index = ~idx; start = 1'b1;
          @(negedge clk); start = 1'b0;
        end
      end
    end
    @(posedge sd_clk); #1;
    chk(cmd_oe === 1'b0 && cmd_out === 1'b1 && cmd_busy === 1'b0, "R2 line released",
        {cmd_oe, cmd_out, cmd_busy}, 3'b010);
    n = 1;
    if (respond) begin
      nb = (wr && lr) ? 136 : 48;
      repeat (dly) @(posedge sd_clk);
      for (int i = nb - 1; i >= 0; i--) begin
        @(posedge sd_clk); #1; cmd_in = rf[i];
      end
      @(posedge sd_clk); #1; cmd_in = 1'b1;
    end
    while (busy && n < 40000) begin
      @(posedge sd_clk); #1; n++;
    end
  endtask

  function automatic logic [47:0] exp_frame(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] h = {2'b01, idx, arg};
    return {h, bcrc({96'd0, h}, 39, 0), 1'b1};
  endfunction

  task automatic full_case(input logic [5:0] idx, input logic [31:0] arg, input bit wr, input bit lr,
                           input bit sk, input bit badc, input bit bade, input int dly, input bit poke);
    logic [135:0] rf;
    logic [47:0] cap;
    logic [6:0] c;
    int n;
    rf = '0;
    if (wr && lr) begin
      rf[135:128] = 8'h3F;
      rf[127:8] = {$urandom, $urandom, $urandom, $urandom};
      c = bcrc(rf, 127, 8);
    end else begin
      rf[47:40] = {2'b00, ~idx};
      rf[39:8] = $urandom;
      c = bcrc(rf, 47, 8);
    end
    rf[7:1] = badc ? (c ^ 7'h01) : c;
    rf[0] = ~bade;
    run_cmd(idx, arg, wr, lr, sk, 16'd50, wr, rf, dly, poke, cap, n);
    chk(cap === exp_frame(idx, arg), poke ? "R10 start ignored, frame" : "R1 frame", cap, exp_frame(idx, arg));
    if (!wr) begin
      chk(n == 1, "R3 busy ends after frame", n, 1);
    end else if (lr) begin
      er[0] = rf[31:0]; er[1] = rf[63:32]; er[2] = rf[95:64]; er[3] = rf[127:96];
    end else begin
      er[0] = rf[39:8];
    end
    chk({resp3, resp2, resp1, resp0} === {er[3], er[2], er[1], er[0]},
        (wr && lr) ? "R5 long words" : "R4 short words",
        {resp3, resp2, resp1, resp0}, {er[3], er[2], er[1], er[0]});
    chk(err_crc === (wr && !sk && badc), "R6 crc flag", err_crc, wr && !sk && badc);
    chk(err_end === (wr && bade), "R7 end flag", err_end, wr && bade);
    chk(err_timeout === 1'b0 && busy === 1'b0, "R9 timeout cleared", {err_timeout, busy}, 2'b00);
  endtask

  initial begin
    logic [47:0] cap;
    int n;
    int s;
    s = $urandom(32'd4711);
    for (int k = 0; k < 4; k++) er[k] = '0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && cmd_busy === 1'b0 && cmd_oe === 1'b0 && cmd_out === 1'b1 &&
        {err_crc, err_end, err_timeout} === 3'b000, "R11 reset outputs",
        {busy, cmd_busy, cmd_oe, cmd_out, err_crc, err_end, err_timeout}, 7'b0001000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({resp3, resp2, resp1, resp0} === 128'd0, "R11 reset words", {resp3, resp2, resp1, resp0}, 128'd0);

    run_cmd(6'd0, 32'd0, 1'b0, 1'b0, 1'b0, 16'd1, 1'b0, '0, 1, 1'b0, cap, n);
    chk(cap === 48'h400000000095, "R1 fixed frame index 0", cap, 48'h400000000095);

    run_cmd(6'd8, 32'h1AA, 1'b1, 1'b0, 1'b0, 16'd1, 1'b0, '0, 1, 1'b0, cap, n);
    chk(n == 4097, "R8 timeout one unit", n, 4097);
    chk(err_timeout === 1'b1, "R8 timeout flag", err_timeout, 1'b1);
    repeat (40) @(negedge clk);
    chk(err_timeout === 1'b1, "R9 flag sticky", err_timeout, 1'b1);

    run_cmd(6'd55, 32'h0, 1'b1, 1'b1, 1'b0, 16'd2, 1'b0, '0, 1, 1'b0, cap, n);
    chk(n == 8193, "R8 timeout two units", n, 8193);

    full_case(6'd17, 32'hDEADBEEF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3, 1'b0);
    full_case(6'd2, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2, 1'b0);
    full_case(6'd13, 32'h12345678, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1, 1'b0);
    full_case(6'd13, 32'h12345678, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1, 1'b0);
    full_case(6'd9, 32'hCAFE0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4, 1'b0);
    full_case(6'd7, 32'hA5A5A5A5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2, 1'b1);

    for (int it = 0; it < 24; it++) begin
      full_case(6'($urandom), $urandom, ($urandom % 4) != 0, $urandom % 2, $urandom % 2,
                ($urandom % 4) == 0, ($urandom % 5) == 0, 1 + ($urandom % 10), 1'b0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule